// File: doc/BRIEF.md
# Zero-Plateau Fault-Leg Locator

This block watches three streams of signed phase-current samples from a three-phase rectifier. It looks for the phase whose current stays near zero for an unusually long time. An open power switch makes its phase current dwell at zero for a large part of a half cycle. A healthy phase only passes through zero briefly.

For each phase, a magnitude comparator decides whether a sample counts as "near zero". The first near-zero sample on an idle phase opens an observation window for that phase, lasting a programmable number of valid samples. Inside the window, a dwell counter counts the near-zero samples. When the window closes, the dwell count is compared against a time threshold expressed in samples. A phase whose dwell strictly exceeds the threshold is reported on a sticky one-hot fault-leg flag. The flag holds until software-side logic pulses a clear.

The raw dwell counts are visible on the outputs while a window runs. They read zero while the phase sleeps. Threshold and window length may be changed at any time, and each phase latches both when its window opens.

Top module: `zero_plateau_locator`

## Requirements
- R1: A sample counts as near-zero only when its magnitude |i| is strictly below `zeroBand`. A magnitude equal to `zeroBand`, and the most negative code, count as non-zero and do not open a window.
- R2: On an idle phase, a valid near-zero sample opens the window, and that phase's count reads 1 after the clock edge.
- R3: While a window is open, each valid sample adds 1 to the count if it is near-zero and leaves the count unchanged otherwise. Cycles with `sampleValid` low change no count.
- R4: A window spans exactly `winLen` valid samples, counting the opening sample as the first. After the last one, the count reads 0 and the phase is idle. A `winLen` of 0 acts as 1.
- R5: At window close, the phase qualifies as faulty when its final count is strictly greater than the threshold latched at window open.
- R6: A change to `timeThresh` during an open window has no effect on that window. It applies from the next window opening.
- R7: `legFlags` (bit 0 = phase A, bit 1 = B, bit 2 = C) is one-hot or zero. If several phases qualify on the same edge, only the lowest-index one is flagged. While any flag is set, no other flag is added.
- R8: A set flag stays set until `clearFlags` is sampled high. The clear zeroes all flags and wins over a flag being set on the same edge. The clear does not touch the counts.
- R9: After reset, all flags and counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Strobe marking a new sample on the three current inputs |
| curA | input | SW | Phase A current sample, two's complement |
| curB | input | SW | Phase B current sample, two's complement |
| curC | input | SW | Phase C current sample, two's complement |
| zeroBand | input | SW | Magnitude below which a sample counts as near-zero |
| timeThresh | input | CW | Dwell threshold in samples, latched at window open |
| winLen | input | CW | Window length in valid samples, latched at window open |
| clearFlags | input | 1 | Clears the fault-leg flags |
| legFlags | output | 3 | Sticky one-hot fault-leg flags, bit 0 = A |
| zeroCounts | output | 3*CW | Live dwell counts, A in the low CW bits, then B, then C |

## Verification
The bench probes the comparator edge with a magnitude exactly equal to the band, and with the most negative code. A design using a non-strict compare, or one whose absolute value wraps, would open a spurious window there. It places a final count equal to the threshold, where an off-by-one compare would raise a false flag. It also reloads the threshold inside an open window: a design that does not latch the threshold would flag a window that should stay quiet. It drives two phases qualifying on the same edge, a clear landing on the same edge as a qualifying close, and a zero window length. Each of these shows up as a wrong or multi-hot flag, or as a window that closes one sample late.

// File: rtl/zpl_pkg.sv
package zpl_pkg;
  localparam int NPH = 3;

  typedef struct packed {
    logic [NPH-1:0] arm;
    logic [NPH-1:0] step;
    logic [NPH-1:0] close;
  } zpl_strobe_t;
endpackage

// File: rtl/zpl_ctrl.sv
module zpl_ctrl
  import zpl_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleValid,
  input  logic [NPH-1:0] zeroHit,
  input  logic [CW-1:0]  winLen,
  output zpl_strobe_t    strb
);
  logic [CW-1:0] winEff;
  assign winEff = (winLen == '0) ? CW'(1) : winLen;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    logic          active;
    logic [CW-1:0] winCnt;
    logic [CW-1:0] winLat;
    logic [CW:0]   winNext;

    assign winNext = {1'b0, winCnt} + (CW+1)'(1);
    assign strb.arm[k]   = sampleValid && !active && zeroHit[k];
    assign strb.step[k]  = sampleValid && active;
    assign strb.close[k] = (strb.arm[k] && winEff == CW'(1)) ||
                           (strb.step[k] && winNext >= {1'b0, winLat});

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        active <= 1'b0;
        winCnt <= '0;
        winLat <= '0;
      end else if (strb.arm[k]) begin
        active <= !strb.close[k];
        winCnt <= CW'(1);
        winLat <= winEff;
      end else if (strb.step[k]) begin
        if (strb.close[k]) begin
          active <= 1'b0;
          winCnt <= '0;
        end else begin
          winCnt <= winNext[CW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/zpl_datapath.sv
module zpl_datapath
  import zpl_pkg::*;
#(
  parameter int SW = 12,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPH*SW-1:0] curFlat,
  input  logic [SW-1:0]     zeroBand,
  input  logic [CW-1:0]     timeThresh,
  input  logic              clearFlags,
  input  zpl_strobe_t       strb,
  output logic [NPH-1:0]    zeroHit,
  output logic [NPH*CW-1:0] zeroCounts,
  output logic [NPH-1:0]    legFlags
);
  logic [NPH-1:0] qual;
  logic [NPH-1:0] pick;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    logic signed [SW:0] ext;
    logic [SW:0]        mag;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      thrLat;
    logic [CW-1:0]      thrUse;
    logic [CW-1:0]      nextCnt;

    assign ext = {curFlat[k*SW+SW-1], curFlat[k*SW +: SW]};
    assign mag = ext[SW] ? 0 - ext : ext;
    assign zeroHit[k] = mag < {1'b0, zeroBand};

    assign nextCnt = strb.arm[k] ? CW'(1) : cnt + CW'(zeroHit[k]);
    assign thrUse  = strb.arm[k] ? timeThresh : thrLat;
    assign qual[k] = strb.close[k] && (nextCnt > thrUse);
    assign zeroCounts[k*CW +: CW] = cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt    <= '0;
        thrLat <= '0;
      end else begin
        if (strb.arm[k]) thrLat <= timeThresh;
        if (strb.close[k]) cnt <= '0;
        else if (strb.arm[k] || strb.step[k]) cnt <= nextCnt;
      end
    end
  end

  assign pick = qual & (~qual + NPH'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) legFlags <= '0;
    else if (clearFlags) legFlags <= '0;
    else if (legFlags == '0 && qual != '0) legFlags <= pick;
  end
endmodule

// File: rtl/zero_plateau_locator.sv
module zero_plateau_locator
  import zpl_pkg::*;
#(
  parameter int SW = 12,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [SW-1:0]     curA,
  input  logic [SW-1:0]     curB,
  input  logic [SW-1:0]     curC,
  input  logic [SW-1:0]     zeroBand,
  input  logic [CW-1:0]     timeThresh,
  input  logic [CW-1:0]     winLen,
  input  logic              clearFlags,
  output logic [2:0]        legFlags,
  output logic [3*CW-1:0]   zeroCounts
);
  zpl_strobe_t    strb;
  logic [NPH-1:0] zeroHit;

  zpl_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .zeroHit(zeroHit), .winLen(winLen), .strb(strb)
  );

  zpl_datapath #(.SW(SW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .curFlat({curC, curB, curA}),
    .zeroBand(zeroBand), .timeThresh(timeThresh), .clearFlags(clearFlags),
    .strb(strb), .zeroHit(zeroHit), .zeroCounts(zeroCounts), .legFlags(legFlags)
  );
endmodule

// File: rtl/zpl_checker.sv
module zpl_checker #(
  parameter int SW = 12,
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            sampleValid,
  input logic [SW-1:0]   curA,
  input logic [SW-1:0]   zeroBand,
  input logic            clearFlags,
  input logic [2:0]      legFlags,
  input logic [3*CW-1:0] zeroCounts
);
  logic signed [SW:0] extA;
  logic [SW:0]        magA;
  logic [CW-1:0]      cntA;
  assign extA = {curA[SW-1], curA};
  assign magA = extA[SW] ? 0 - extA : extA;
  assign cntA = zeroCounts[CW-1:0];

  // R7
  onehot_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(legFlags));

  // R8
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legFlags != 3'b0 && !clearFlags) |=> legFlags == $past(legFlags));

  // R8
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags |=> legFlags == 3'b0);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(zeroCounts));

  // R3
  no_flag_rise_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> (legFlags == $past(legFlags) || legFlags == 3'b0));

  // R1
  no_false_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && cntA == '0 && magA >= {1'b0, zeroBand}) |=> cntA == '0);

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (cntA == '0 || {1'b0, cntA} <= {1'b0, $past(cntA)} + (CW+1)'(1)));
endmodule

bind zero_plateau_locator zpl_checker #(.SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .curA(curA),
  .zeroBand(zeroBand), .clearFlags(clearFlags), .legFlags(legFlags),
  .zeroCounts(zeroCounts)
);

// File: tb/tb_zero_plateau_locator.sv
module tb_zero_plateau_locator;
  localparam int SW = 12;
  localparam int CW = 16;

  logic clk = 0;
  logic rstN = 0;
  logic sampleValid = 0;
  logic [SW-1:0] curA = '0, curB = '0, curC = '0;
  logic [SW-1:0] zeroBand = 12'd50;
  logic [CW-1:0] timeThresh = 16'd2;
  logic [CW-1:0] winLen = 16'd4;
  logic clearFlags = 0;
  logic [2:0] legFlags;
  logic [3*CW-1:0] zeroCounts;

  int nTests = 0, nFail = 0;
  bit done = 0;

  // reference state
  bit mAct[3];
  int mWc[3], mWl[3], mCnt[3], mThr[3];
  int mFlags;

  zero_plateau_locator #(.SW(SW), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .curA(curA), .curB(curB),
    .curC(curC), .zeroBand(zeroBand), .timeThresh(timeThresh), .winLen(winLen),
    .clearFlags(clearFlags), .legFlags(legFlags), .zeroCounts(zeroCounts)
  );

  always #4 clk = ~clk;

  function automatic bit isZero(int v);
    int m = (v < 0) ? -v : v;
    return m < int'(zeroBand);
  endfunction

  function automatic int cntOf(int k);
    return int'(zeroCounts[k*CW +: CW]);
  endfunction

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(bit v, int a, int b, int c, bit clr);
    int cur[3];
    int qual = 0;
    cur[0] = a; cur[1] = b; cur[2] = c;
    if (v) begin
      for (int k = 0; k < 3; k++) begin
        bit z = isZero(cur[k]);
        bit closeNow = 0;
        if (!mAct[k]) begin
          if (z) begin
            mAct[k] = 1; mWc[k] = 1; mCnt[k] = 1;
            mWl[k] = (winLen == 0) ? 1 : int'(winLen);
            mThr[k] = int'(timeThresh);
            closeNow = (mWc[k] >= mWl[k]);
          end
        end else begin
          mWc[k]++;
          mCnt[k] += z ? 1 : 0;
          closeNow = (mWc[k] >= mWl[k]);
        end
        if (closeNow) begin
          if (mCnt[k] > mThr[k]) qual |= (1 << k);
          mAct[k] = 0; mCnt[k] = 0; mWc[k] = 0;
        end
      end
    end
    if (clr) mFlags = 0;
    else if (mFlags == 0 && qual != 0) begin
      if (qual & 1) mFlags = 1;
      else if (qual & 2) mFlags = 2;
      else mFlags = 4;
    end
  endtask

  // called at a negedge; outputs are compared at the following negedge
  task automatic tick(bit v, int a, int b, int c, bit clr, string tag);
    sampleValid = v; curA = a[SW-1:0]; curB = b[SW-1:0]; curC = c[SW-1:0];
    clearFlags = clr;
    modelStep(v, a, b, c, clr);
    @(negedge clk);
    check({tag, " flags"}, int'(legFlags), mFlags);
    for (int k = 0; k < 3; k++) check({tag, " count"}, cntOf(k), mCnt[k]);
    sampleValid = 0; clearFlags = 0;
  endtask

  function automatic int rndCur();
    int r = $urandom % 8;
    if (r < 3) return int'($urandom % 140) - 70;
    return int'($urandom % 3000) - 1500;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) begin mAct[k] = 0; mWc[k] = 0; mWl[k] = 0; mCnt[k] = 0; mThr[k] = 0; end
    mFlags = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 flags", int'(legFlags), 0);
    check("R9 countA", cntOf(0), 0);
    rstN = 1;
    @(negedge clk);

    // R1: magnitude equal to band and most negative code do not arm
    tick(1, 50, 1000, -1000, 0, "R1");
    check("R1 band edge", cntOf(0), 0);
    tick(1, -2048, 1000, -1000, 0, "R1");
    check("R1 min code", cntOf(0), 0);
    // R2: -49 arms
    tick(1, -49, 1000, -1000, 0, "R2");
    check("R2 arm count", cntOf(0), 1);
    // R3: invalid cycle and non-zero sample hold
    tick(0, 0, 0, 0, 0, "R3");
    check("R3 idle hold", cntOf(0), 1);
    tick(1, 500, 1000, -1000, 0, "R3");
    check("R3 nonzero hold", cntOf(0), 1);
    tick(1, 10, 1000, -1000, 0, "R3");
    check("R3 increment", cntOf(0), 2);
    // R4/R5: 4th sample closes with count 3 > 2
    tick(1, 0, 1000, -1000, 0, "R5");
    check("R5 flag A", int'(legFlags), 1);
    check("R4 count cleared", cntOf(0), 0);
    // R8: sticky then clear
    tick(0, 0, 0, 0, 0, "R8");
    check("R8 sticky", int'(legFlags), 1);
    tick(0, 0, 0, 0, 1, "R8");
    check("R8 cleared", int'(legFlags), 0);
    // R5: count equal to threshold does not qualify
    tick(1, 0, 1000, 1000, 0, "R5");
    tick(1, 0, 1000, 1000, 0, "R5");
    tick(1, 900, 1000, 1000, 0, "R5");
    tick(1, 900, 1000, 1000, 0, "R5");
    check("R5 equal no flag", int'(legFlags), 0);
    // R6: threshold drop mid-window ignored
    tick(1, 0, 1000, 1000, 0, "R6");
    timeThresh = 0;
    tick(1, 900, 1000, 1000, 0, "R6");
    tick(1, 900, 1000, 1000, 0, "R6");
    tick(1, 900, 1000, 1000, 0, "R6");
    check("R6 old thr kept", int'(legFlags), 0);
    tick(1, 0, 1000, 1000, 0, "R6");
    tick(1, 900, 1000, 1000, 0, "R6");
    tick(1, 900, 1000, 1000, 0, "R6");
    tick(1, 900, 1000, 1000, 0, "R6");
    check("R6 new thr used", int'(legFlags), 1);
    tick(0, 0, 0, 0, 1, "R8");
    // R7: B and C qualify together -> B only
    timeThresh = 1;
    for (int i = 0; i < 4; i++) tick(1, 900, 3, -3, 0, "R7");
    check("R7 lowest index", int'(legFlags), 2);
    for (int i = 0; i < 4; i++) tick(1, 900, 900, 0, 0, "R7");
    check("R7 no second flag", int'(legFlags), 2);
    tick(0, 0, 0, 0, 1, "R8");
    // R8: clear wins on same edge as qualifying close
    for (int i = 0; i < 3; i++) tick(1, 0, 900, 900, 0, "R8");
    tick(1, 0, 900, 900, 1, "R8");
    check("R8 clear priority", int'(legFlags), 0);
    // R4: winLen 0 acts as 1
    winLen = 0; timeThresh = 0;
    tick(1, 5, 900, 900, 0, "R4");
    check("R4 zero len flag", int'(legFlags), 1);
    check("R4 zero len count", cntOf(0), 0);
    tick(0, 0, 0, 0, 1, "R8");

    // random phase
    winLen = 20; timeThresh = 8;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 200 == 0) timeThresh = CW'($urandom % 16);
      if ($urandom % 300 == 0) winLen = CW'($urandom % 24);
      tick(($urandom % 4) != 0, rndCur(), rndCur(), rndCur(),
           ($urandom % 60) == 0, "R3 R4 R5 R7 R8");
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule